// File: doc/BRIEF.md
# Manchester Line Encoder with Programmable Preamble

This block takes bytes from a valid/ready source and sends them one at a time on a single serial line using Manchester coding. Each bit period is made of two half-bit phases, and the line always changes level between them. A half-bit phase lasts from one pulse of the `half_tick` input to the next. The bit period is therefore two tick intervals, and the rate is set entirely by whoever produces the tick.

A frame can start with a preamble whose length is programmable from 0 to 15 bit periods. The preamble uses one of four patterns, and the data byte follows it directly with no gap. The preamble length, the pattern and the coding polarity are held in a configuration register. That register is loaded through `cfg_wr` and is frozen while `wr_protect` is high. At frame start the block takes a private copy of the configuration, so a write during a frame only affects later frames.

Top module: `mantx_top`

## Requirements
- R1: Reset makes the block idle: `line_o` high, `busy_o` low, `in_ready` high. The stored configuration after reset has length 0, pattern 00 and polarity 0.
- R2: With preamble length 0, a frame is exactly the 8 data bits, which is 16 half-bit phases.
- R3: With preamble length n (1 to 15), exactly n preamble bits are sent before the first data bit.
- R4: The pattern code picks the preamble bit values. Code 00 sends all ones and 01 sends all zeros. Code 10 alternates starting with zero (0,1,0,...), and code 11 alternates starting with one (1,0,1,...).
- R5: Each bit, whether preamble or data, is coded as follows. The first half-bit level is the bit XOR the polarity, and the second half-bit is its inverse. With polarity 0 a logic 0 is low-to-high and a logic 1 is high-to-low. Polarity 1 swaps both.
- R6: Data bits are sent least significant bit first. Data bit 0 occupies the bit period directly after the last preamble bit.
- R7: A byte is accepted only on a clock edge where `in_valid`, `in_ready` and `half_tick` are all high. The first half-bit appears on `line_o` after that edge, and each later half-bit appears after the next edge with `half_tick` high. Between ticks the line holds its level.
- R8: `busy_o` is high from the first half-bit of a frame until the clock edge that ends its last half-bit, and `in_ready` is always its inverse.
- R9: While idle, `line_o` is 1 XOR the stored polarity, which is the first half-bit level of a logic 1.
- R10: A configuration write presented while `wr_protect` is high changes nothing. This shows on the idle level and on the next frame.
- R11: A configuration write made during a frame does not change that frame. It applies from the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-cycle pulse marking each half-bit boundary |
| cfg_wr | input | 1 | Configuration write strobe |
| wr_protect | input | 1 | When high, configuration writes are ignored |
| cfg_plen | input | 4 | Preamble length in bit periods (0 disables the preamble) |
| cfg_pat | input | 2 | Preamble pattern code |
| cfg_pol | input | 1 | Manchester polarity |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send, LSB first |
| in_ready | output | 1 | Block is idle and will take a byte on the next tick |
| line_o | output | 1 | Manchester-coded serial line |
| busy_o | output | 1 | Frame in progress |

## Verification
Two situations are the hardest to reach from the ports. One is a configuration write that lands between two half-bits in the middle of a frame. The other is a protected write, whose effect would only show on the idle level and on the following frame. The bench controls the tick directly, so it can insert a write strobe in the gap cycle inside a chosen half-bit and then check that the rest of that frame keeps the old polarity and length. For protected writes, the bench sends a frame after the attempt and checks that its length and coding match the old configuration.

// File: rtl/mantx_pkg.sv
package mantx_pkg;
    localparam int PLEN_W = 4;
    localparam int PAT_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [PLEN_W-1:0] plen;
        logic [PAT_W-1:0]  pat;
        logic              pol;
    } tx_cfg_t;

    localparam logic [PAT_W-1:0] PAT_ONES     = 2'b00;
    localparam logic [PAT_W-1:0] PAT_ZEROS    = 2'b01;
    localparam logic [PAT_W-1:0] PAT_ZERO_ONE = 2'b10;
    localparam logic [PAT_W-1:0] PAT_ONE_ZERO = 2'b11;
endpackage

// File: rtl/mantx_cfg.sv
module mantx_cfg
    import mantx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  logic    wp_en,
    input  tx_cfg_t wr_cfg,
    output tx_cfg_t cfg_q
);
    tx_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && !wp_en) begin
            cfg_d = wr_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // R10: a protected write leaves the stored configuration untouched
    p_wp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_en) |=> $stable(cfg_q));
endmodule

// File: rtl/mantx_pre.sv
module mantx_pre
    import mantx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [PAT_W-1:0] pat,
    input  logic [CNT_W-1:0] idx,
    output logic             bit_o
);
    always_comb begin
        unique case (pat)
            PAT_ONES:     bit_o = 1'b1;
            PAT_ZEROS:    bit_o = 1'b0;
            PAT_ZERO_ONE: bit_o = idx[0];
            default:      bit_o = ~idx[0];
        endcase
    end
endmodule

// File: rtl/mantx_coder.sv
module mantx_coder (
    input  logic bit_i,
    input  logic half_i,
    input  logic pol_i,
    output logic lvl_o
);
    always_comb begin
        lvl_o = bit_i ^ pol_i ^ half_i;
    end
endmodule

// File: rtl/mantx_seq.sv
module mantx_seq
    import mantx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  tx_cfg_t           cfg,
    output logic              in_ready,
    output logic              line_o,
    output logic              busy_o
);
    localparam int MAXCNT = (2**PLEN_W > DATA_W) ? 2**PLEN_W : DATA_W;
    localparam int CNT_W  = $clog2(MAXCNT);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  idx;
        logic              half;
        logic [DATA_W-1:0] shreg;
        tx_cfg_t           snap;
        logic              busy;
        logic              ready;
    } seq_t;

    seq_t s_d, s_q;
    logic line_d, line_q;
    logic pre_bit, cur_bit, cur_half, cur_pol;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (tick && in_valid) begin
                    s_d.snap  = cfg;
                    s_d.shreg = in_data;
                    s_d.idx   = '0;
                    s_d.half  = 1'b0;
                    s_d.st    = (cfg.plen != '0) ? ST_PRE : ST_DATA;
                end
            end
            ST_PRE: begin
                if (tick) begin
                    s_d.half = ~s_q.half;
                    if (s_q.half) begin
                        if (s_q.idx == CNT_W'(s_q.snap.plen) - CNT_W'(1)) begin
                            s_d.idx = '0;
                            s_d.st  = ST_DATA;
                        end else begin
                            s_d.idx = s_q.idx + CNT_W'(1);
                        end
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    s_d.half = ~s_q.half;
                    if (s_q.half) begin
                        s_d.shreg = s_q.shreg >> 1;
                        if (s_q.idx == LAST_DATA) begin
                            s_d.idx = '0;
                            s_d.st  = ST_IDLE;
                        end else begin
                            s_d.idx = s_q.idx + CNT_W'(1);
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        s_d.busy  = (s_d.st != ST_IDLE);
        s_d.ready = (s_d.st == ST_IDLE);
    end

    mantx_pre #(.CNT_W(CNT_W)) u_pre (
        .pat   (s_d.snap.pat),
        .idx   (s_d.idx),
        .bit_o (pre_bit)
    );

    always_comb begin
        unique case (s_d.st)
            ST_PRE:  cur_bit = pre_bit;
            ST_DATA: cur_bit = s_d.shreg[0];
            default: cur_bit = 1'b1;
        endcase
        cur_half = (s_d.st == ST_IDLE) ? 1'b0 : s_d.half;
        cur_pol  = (s_d.st == ST_IDLE) ? cfg.pol : s_d.snap.pol;
    end

    mantx_coder u_coder (
        .bit_i  (cur_bit),
        .half_i (cur_half),
        .pol_i  (cur_pol),
        .lvl_o  (line_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.ready <= 1'b1;
            line_q    <= 1'b1;
        end else begin
            s_q    <= s_d;
            line_q <= line_d;
        end
    end

    assign in_ready = s_q.ready;
    assign busy_o   = s_q.busy;
    assign line_o   = line_q;

    // R7: without a tick an active frame holds its level
    p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !tick) |=> $stable(line_q));
    // R7: a frame only begins on a tick edge
    p_start_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> $past(tick));
    // R11: the frame copy of the configuration is frozen while busy
    p_snap_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> (!s_q.busy || $stable(s_q.snap)));
    // R3: the preamble counter stays below the programmed length
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_PRE) |-> (s_q.idx < CNT_W'(s_q.snap.plen)));
    // R9: steady idle level follows the stored polarity
    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !$past(s_q.busy)) |-> (line_q == ~$past(cfg.pol)));
endmodule

// File: rtl/mantx_top.sv
module mantx_top
    import mantx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              cfg_wr,
    input  logic              wr_protect,
    input  logic [3:0]        cfg_plen,
    input  logic [1:0]        cfg_pat,
    input  logic              cfg_pol,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              line_o,
    output logic              busy_o
);
    tx_cfg_t wr_cfg, cfg_q;

    always_comb begin
        wr_cfg.plen = cfg_plen;
        wr_cfg.pat  = cfg_pat;
        wr_cfg.pol  = cfg_pol;
    end

    mantx_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .wp_en  (wr_protect),
        .wr_cfg (wr_cfg),
        .cfg_q  (cfg_q)
    );

    mantx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (half_tick),
        .in_valid (in_valid),
        .in_data  (in_data),
        .cfg      (cfg_q),
        .in_ready (in_ready),
        .line_o   (line_o),
        .busy_o   (busy_o)
    );

    // R8: ready is always the inverse of busy
    p_busy_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o != in_ready));
endmodule

// File: tb/tb_mantx_top.sv
module tb_mantx_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       wr_protect = 1'b0;
    logic [3:0] cfg_plen = '0;
    logic [1:0] cfg_pat = '0;
    logic       cfg_pol = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, line_o, busy_o;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mantx_top dut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .cfg_wr(cfg_wr),
        .wr_protect(wr_protect), .cfg_plen(cfg_plen), .cfg_pat(cfg_pat),
        .cfg_pol(cfg_pol), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .line_o(line_o), .busy_o(busy_o)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_half(input int plen, input int pat, input int pol,
                                      input logic [7:0] data, input int i);
        int b = i / 2;
        int h = i % 2;
        int v;
        if (b < plen) begin
            case (pat)
                0: v = 1;
                1: v = 0;
                2: v = b % 2;
                default: v = 1 - (b % 2);
            endcase
        end else begin
            v = int'(data[b - plen]);
        end
        return logic'((v ^ pol ^ h) & 1);
    endfunction

    task automatic wcfg(input int plen, input int pat, input int pol, input logic wp);
        @(negedge clk);
        cfg_plen = 4'(plen); cfg_pat = 2'(pat); cfg_pol = 1'(pol);
        wr_protect = wp; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // plen/pat/pol: configuration the frame must use; mid: write during frame
    task automatic send(input int plen, input int pat, input int pol, input logic [7:0] data,
                        input bit mid, input int idle_pol);
        int n = 2 * (plen + 8);
        @(negedge clk);
        in_valid = 1'b1; in_data = data; half_tick = 1'b0;
        @(negedge clk);
        chk(busy_o, 1'b0, "R7 no accept without tick");
        half_tick = 1'b1;
        @(negedge clk);
        half_tick = 1'b0; in_valid = 1'b0;
        chk(line_o, exp_half(plen, pat, pol, data, 0), "R5 first half-bit");
        chk(busy_o, 1'b1, "R8 busy on first half-bit");
        chk(in_ready, 1'b0, "R8 ready low while busy");
        for (int i = 1; i < n; i++) begin
            half_tick = 1'b1;
            @(negedge clk);
            half_tick = 1'b0;
            chk(line_o, exp_half(plen, pat, pol, data, i),
                (i < 2*plen) ? "R3/R4 preamble half-bit" : "R2/R5/R6 data half-bit");
            chk(busy_o, 1'b1, "R8 busy through frame");
            if (mid && i == 5) begin
                cfg_plen = 4'd0; cfg_pat = 2'd0; cfg_pol = 1'(idle_pol);
                wr_protect = 1'b0; cfg_wr = 1'b1;
            end
            @(negedge clk);
            cfg_wr = 1'b0;
            chk(line_o, exp_half(plen, pat, pol, data, i), "R7/R11 level held between ticks");
        end
        half_tick = 1'b1;
        @(negedge clk);
        half_tick = 1'b0;
        chk(busy_o, 1'b0, "R8 busy clears after last half-bit");
        chk(in_ready, 1'b1, "R8 ready returns");
        chk(line_o, logic'(1 ^ idle_pol), "R9 idle level after frame");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(line_o, 1'b1, "R1 reset line");
        chk(busy_o, 1'b0, "R1 reset busy");
        chk(in_ready, 1'b1, "R1 reset ready");
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_o, 1'b1, "R1 idle line after reset");
        // R1: reset config is length 0, pattern 00, polarity 0
        send(0, 0, 0, 8'hA5, 1'b0, 0);

        // R2..R6: sweep every length, pattern and polarity
        for (int pol = 0; pol < 2; pol++) begin
            for (int pat = 0; pat < 4; pat++) begin
                for (int pl = 0; pl < 16; pl++) begin
                    wcfg(pl, pat, pol, 1'b0);
                    send(pl, pat, pol, 8'((pl * 37 + pat * 11 + pol * 101 + 5) & 8'hFF),
                         1'b0, pol);
                end
            end
        end
        wcfg(0, 0, 1, 1'b0);
        send(0, 0, 1, 8'h00, 1'b0, 1);
        send(0, 0, 1, 8'hFF, 1'b0, 1);
        send(0, 0, 1, 8'h01, 1'b0, 1);

        // R10: protected writes change neither idle level nor next frame
        wcfg(3, 2, 0, 1'b0);
        wcfg(9, 1, 1, 1'b1);
        @(negedge clk);
        chk(line_o, 1'b1, "R10 idle level kept under protect");
        send(3, 2, 0, 8'h3C, 1'b0, 0);
        wr_protect = 1'b0;

        // R11: write in mid-frame; current frame keeps old config
        wcfg(5, 3, 0, 1'b0);
        send(5, 3, 0, 8'h96, 1'b1, 1);
        send(0, 0, 1, 8'h69, 1'b0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule